// File: doc/BRIEF.md
# Rotating Register Window Controller

This block keeps a windowed general register file. A physical array of `NAREG` 32-bit registers is seen through a 16-register window whose origin, the window base, moves in steps of four registers. A bitmap with one bit per window marks which windows hold a live call frame. The block carries out the window operations of a processor pipeline: it enters a called frame, returns from one, rotates the window to an absolute or relative position, restores the base saved at the last window trap, and checks whether a stack-pointer move is safe.

Each operation is presented for one cycle together with the processor status fields it needs: the window-overflow enable, the exception-mode flag, the call increment and the saved base. One cycle later the block reports a result code. The code is done, illegal, overflow of 4, 8 or 12 registers, underflow of 4, 8 or 12 registers, or stack-move fault. For returns it also reports the return address. On an overflow or underflow it also gives the base to save and a request to set exception mode. The trap handlers that spill and refill frames sit outside the block. They use the visible register port while the window is rotated to the frame in question.

Top module: `rwin_controller`

## Requirements
- R1: After reset the window base is 0, the window-live bitmap is 0x1 (only window 0 live) and `res_valid` is low.
- R2: Visible register i reads and writes physical register (base*4 + i) mod NAREG, so the same physical register is reached under different bases, including across the wrap of the array.
- R3: Operation kinds are 0 call-entry, 1 return, 2 stack-move check, 3 absolute rotate, 4 relative rotate, 5 restore from saved base; 6 and 7 are illegal. Call-entry is illegal (result code 1, base and bitmap unchanged) when the stack register index exceeds 3, the overflow enable is low, or exception mode is set.
- R4: A legal call-entry without overflow writes visible register (callinc*4 + s) with visible register s minus imm*8, moves the base up by callinc, sets the bitmap bit of the new base, and reports code 0.
- R5: A call-entry overflows when any of the lowest callinc bitmap bits, counted upward from base+1 with wrap, is set. With n one plus the position of the first such bit, the base moves up by n. Next the bits upward from base+1+n are scanned: if the first is set the code is 2 (overflow 4); if only the second is set it is 3 (overflow 8); otherwise it is 4 (overflow 12). No register is written and the bitmap is unchanged.
- R6: On every overflow or underflow `res_excm_set` is high and `res_owb` holds the base from before the operation; for every other result `res_excm_set` is low.
- R7: A return takes n from bits 31:30 of visible register 0 and reports the return address as op_pc bits 31:30 joined with register 0 bits 29:0. If the bitmap bit of base-n is set, the base becomes base-n, the old base's bit is cleared and the code is 0.
- R8: With m = 1, 2 or 3 for the first set bitmap bit among base-1, base-2, base-3 (0 if none), a return is illegal (code 1, return address 0, state unchanged) when n is 0, when m is nonzero and differs from n, or when the overflow enable is low or exception mode set.
- R9: A legal return whose new base has a clear bitmap bit moves the base to base-n, leaves the bitmap unchanged and reports code 5, 6 or 7 (underflow 4, 8, 12) for n of 1, 2 or 3.
- R10: The stack-move check reports code 8 when none of the bitmap bits at base-1, base-2, base-3 is set, and 0 otherwise; it changes neither base nor bitmap.
- R11: Absolute rotate sets the base to op_arg mod NAREG/4; relative rotate adds op_arg as a signed 4-bit value mod NAREG/4; restore sets the base to `ps_owb`. None of them changes the bitmap.
- R12: The result of an operation appears the cycle after it is presented and `res_valid` is a one-cycle pulse per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation presented this cycle |
| op_kind | input | 3 | Operation kind (R3 encoding) |
| op_sreg | input | 4 | Stack register index for call-entry |
| op_imm | input | IMM_W | Frame size for call-entry, in 8-byte units |
| op_arg | input | 4 | Rotate target or signed rotate amount |
| op_pc | input | 32 | Address of the operation |
| ps_woe | input | 1 | Window overflow enable |
| ps_excm | input | 1 | Exception mode flag |
| ps_callinc | input | 2 | Call increment |
| ps_owb | input | BW | Saved base used by restore |
| rf_we | input | 1 | Visible register write enable (ignored while op_valid) |
| rf_waddr | input | 4 | Visible register write index |
| rf_wdata | input | 32 | Visible register write data |
| rf_raddr | input | 4 | Visible register read index |
| rf_rdata | output | 32 | Visible register read data |
| res_valid | output | 1 | Result pulse |
| res_code | output | 4 | Result code |
| res_ret_pc | output | 32 | Return address |
| res_owb | output | BW | Base to save on a window trap |
| res_excm_set | output | 1 | Request to set exception mode |
| win_base | output | BW | Current window base |
| win_start | output | NW | Window-live bitmap |

## Verification
The bench builds the block with NAREG = 32, so there are eight windows and a 3-bit base. That small base lets a few rotations wrap both the physical array and the bitmap, and it puts all three overflow sizes and all three underflow sizes within a handful of operations from reset. The bitmap patterns that select each trap size are set up through ordinary call-entries and rotations rather than forced.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

  localparam int XLEN = 32;

  typedef enum logic [2:0] {
    K_ENTRY    = 3'd0,
    K_RETURN   = 3'd1,
    K_STACKCHK = 3'd2,
    K_ROT_ABS  = 3'd3,
    K_ROT_REL  = 3'd4,
    K_RESTORE  = 3'd5
  } op_kind_e;

  typedef enum logic [3:0] {
    C_DONE    = 4'd0,
    C_ILLEGAL = 4'd1,
    C_OVF4    = 4'd2,
    C_OVF8    = 4'd3,
    C_OVF12   = 4'd4,
    C_UNF4    = 4'd5,
    C_UNF8    = 4'd6,
    C_UNF12   = 4'd7,
    C_ALLOCA  = 4'd8
  } res_code_e;

endpackage

// File: rtl/rwin_phys_rf.sv
// Physical register array seen through a movable window of 16.
module rwin_phys_rf #(
  parameter int NAREG = 64,
  parameter int NRD   = 3,
  localparam int PW   = $clog2(NAREG),
  localparam int BW   = PW - 2
) (
  input  logic                        clk,
  input  logic [BW-1:0]               base,
  input  logic [NRD-1:0][3:0]         rd_idx,
  output logic [NRD-1:0][rwin_pkg::XLEN-1:0] rd_data,
  input  logic                        wr_en,
  input  logic [3:0]                  wr_idx,
  input  logic [rwin_pkg::XLEN-1:0]   wr_data
);
  logic [rwin_pkg::XLEN-1:0] mem [NAREG];
  logic [PW-1:0] wr_phys;

  // window origin in register units; width PW wraps modulo NAREG
  assign wr_phys = {base, 2'b00} + PW'(wr_idx);

  // data array: no reset, written only under its enable
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_phys] <= wr_data;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    logic [PW-1:0] rd_phys;
    assign rd_phys    = {base, 2'b00} + PW'(rd_idx[g]);
    assign rd_data[g] = mem[rd_phys];
  end

endmodule

// File: rtl/rwin_eval.sv
// Combinational evaluation of one window operation against current state.
module rwin_eval
  import rwin_pkg::*;
#(
  parameter int NAREG = 64,
  parameter int IMM_W = 12,
  localparam int NW   = NAREG / 4,
  localparam int BW   = $clog2(NW)
) (
  input  logic [BW-1:0]    base,
  input  logic [NW-1:0]    ws,
  input  logic [2:0]       op_kind,
  input  logic [3:0]       op_sreg,
  input  logic [IMM_W-1:0] op_imm,
  input  logic [3:0]       op_arg,
  input  logic [XLEN-1:0]  op_pc,
  input  logic             ps_woe,
  input  logic             ps_excm,
  input  logic [1:0]       ps_callinc,
  input  logic [BW-1:0]    ps_owb,
  input  logic [XLEN-1:0]  reg_s,
  input  logic [XLEN-1:0]  reg_0,
  output logic [BW-1:0]    nxt_base,
  output logic [NW-1:0]    nxt_ws,
  output logic             wr_en,
  output logic [3:0]       wr_idx,
  output logic [XLEN-1:0]  wr_data,
  output logic [3:0]       code,
  output logic [XLEN-1:0]  ret_pc,
  output logic             excm_set
);

  // rotate the bitmap right by k with wrap (bit k lands at position 0)
  function automatic logic [NW-1:0] rotr(input logic [NW-1:0] v, input logic [BW-1:0] k);
    logic [2*NW-1:0] d;
    d = {v, v} >> k;
    return d[NW-1:0];
  endfunction

  logic          frame_ok;
  logic [NW-1:0] ent_rot, ent_rot2;
  logic [2:0]    ent_mask, ent_hit;
  logic [1:0]    ent_n;
  logic [BW-1:0] ent_base;
  res_code_e     ent_ovf;
  logic          back1, back2, back3;
  logic [1:0]    ret_n, ret_m;
  logic [BW-1:0] ret_base;
  res_code_e     ret_unf;

  assign frame_ok = ps_woe & ~ps_excm;

  // overflow scan upward from base+1
  assign ent_rot = rotr(ws, base + BW'(1));
  always_comb begin
    unique case (ps_callinc)
      2'd0:    ent_mask = 3'b000;
      2'd1:    ent_mask = 3'b001;
      2'd2:    ent_mask = 3'b011;
      default: ent_mask = 3'b111;
    endcase
  end
  assign ent_hit  = ent_rot[2:0] & ent_mask;
  assign ent_n    = ent_hit[0] ? 2'd1 : (ent_hit[1] ? 2'd2 : 2'd3);
  assign ent_rot2 = rotr(ws, base + BW'(1) + BW'(ent_n));
  assign ent_ovf  = ent_rot2[0] ? C_OVF4 : (ent_rot2[1] ? C_OVF8 : C_OVF12);
  assign ent_base = base + BW'(ps_callinc);

  // caller-frame scan downward from base-1
  assign back1    = ws[base - BW'(1)];
  assign back2    = ws[base - BW'(2)];
  assign back3    = ws[base - BW'(3)];
  assign ret_n    = reg_0[XLEN-1:XLEN-2];
  assign ret_m    = back1 ? 2'd1 : (back2 ? 2'd2 : (back3 ? 2'd3 : 2'd0));
  assign ret_base = base - BW'(ret_n);
  assign ret_unf  = (ret_n == 2'd1) ? C_UNF4 : ((ret_n == 2'd2) ? C_UNF8 : C_UNF12);

  always_comb begin
    nxt_base = base;
    nxt_ws   = ws;
    wr_en    = 1'b0;
    wr_idx   = 4'd0;
    wr_data  = '0;
    code     = C_DONE;
    ret_pc   = '0;
    excm_set = 1'b0;
    unique case (op_kind)
      K_ENTRY: begin
        if (op_sreg > 4'd3 || !frame_ok) begin
          code = C_ILLEGAL;
        end else if (|ent_hit) begin
          code     = ent_ovf;
          nxt_base = base + BW'(ent_n);
          excm_set = 1'b1;
        end else begin
          wr_en    = 1'b1;
          wr_idx   = {ps_callinc, op_sreg[1:0]};
          wr_data  = reg_s - (XLEN'(op_imm) << 3);
          nxt_base = ent_base;
          nxt_ws   = ws | (NW'(1) << ent_base);
        end
      end
      K_RETURN: begin
        if (ret_n == 2'd0 || (ret_m != 2'd0 && ret_m != ret_n) || !frame_ok) begin
          code = C_ILLEGAL;
        end else begin
          ret_pc   = {op_pc[XLEN-1:XLEN-2], reg_0[XLEN-3:0]};
          nxt_base = ret_base;
          if (ws[ret_base]) begin
            nxt_ws = ws & ~(NW'(1) << base);
          end else begin
            code     = ret_unf;
            excm_set = 1'b1;
          end
        end
      end
      K_STACKCHK: begin
        if (!(back1 | back2 | back3)) code = C_ALLOCA;
      end
      K_ROT_ABS: nxt_base = BW'(op_arg);
      K_ROT_REL: nxt_base = base + BW'($signed(op_arg));
      K_RESTORE: nxt_base = ps_owb;
      default:   code = C_ILLEGAL;
    endcase
  end

  // R4: the array is only written by a legal, non-overflowing call-entry
  always_comb begin
    if (wr_en) begin
      a_write_only_entry_r4: assert (op_kind == K_ENTRY && frame_ok && code == C_DONE);
    end
  end

endmodule

// File: rtl/rwin_controller.sv
module rwin_controller
  import rwin_pkg::*;
#(
  parameter int NAREG = 64,
  parameter int IMM_W = 12,
  localparam int NW   = NAREG / 4,
  localparam int BW   = $clog2(NW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [2:0]       op_kind,
  input  logic [3:0]       op_sreg,
  input  logic [IMM_W-1:0] op_imm,
  input  logic [3:0]       op_arg,
  input  logic [31:0]      op_pc,
  input  logic             ps_woe,
  input  logic             ps_excm,
  input  logic [1:0]       ps_callinc,
  input  logic [BW-1:0]    ps_owb,
  input  logic             rf_we,
  input  logic [3:0]       rf_waddr,
  input  logic [31:0]      rf_wdata,
  input  logic [3:0]       rf_raddr,
  output logic [31:0]      rf_rdata,
  output logic             res_valid,
  output logic [3:0]       res_code,
  output logic [31:0]      res_ret_pc,
  output logic [BW-1:0]    res_owb,
  output logic             res_excm_set,
  output logic [BW-1:0]    win_base,
  output logic [NW-1:0]    win_start
);
  localparam int NRD = 3;

  // architectural state
  logic [BW-1:0]   q_base, d_base;
  logic [NW-1:0]   q_ws,   d_ws;
  logic            q_rv,   d_rv;
  logic [3:0]      q_code, d_code;
  logic [XLEN-1:0] q_rpc,  d_rpc;
  logic [BW-1:0]   q_owb,  d_owb;
  logic            q_exs,  d_exs;
  logic [2:0]      q_kind, d_kind;

  // evaluation outputs
  logic [BW-1:0]   e_base;
  logic [NW-1:0]   e_ws;
  logic            e_we;
  logic [3:0]      e_widx;
  logic [XLEN-1:0] e_wdata;
  logic [3:0]      e_code;
  logic [XLEN-1:0] e_rpc;
  logic            e_exs;

  // register array ports
  logic [NRD-1:0][3:0]      rd_idx;
  logic [NRD-1:0][XLEN-1:0] rd_data;
  logic                     a_we;
  logic [3:0]               a_widx;
  logic [XLEN-1:0]          a_wdata;

  assign rd_idx[0] = rf_raddr;
  assign rd_idx[1] = op_sreg;
  assign rd_idx[2] = 4'd0;

  // an operation owns the write port; the external port yields to it
  always_comb begin
    if (op_valid) begin
      a_we    = e_we;
      a_widx  = e_widx;
      a_wdata = e_wdata;
    end else begin
      a_we    = rf_we;
      a_widx  = rf_waddr;
      a_wdata = rf_wdata;
    end
  end

  rwin_phys_rf #(.NAREG(NAREG), .NRD(NRD)) u_rf (
    .clk     (clk),
    .base    (q_base),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .wr_en   (a_we),
    .wr_idx  (a_widx),
    .wr_data (a_wdata)
  );

  rwin_eval #(.NAREG(NAREG), .IMM_W(IMM_W)) u_eval (
    .base       (q_base),
    .ws         (q_ws),
    .op_kind    (op_kind),
    .op_sreg    (op_sreg),
    .op_imm     (op_imm),
    .op_arg     (op_arg),
    .op_pc      (op_pc),
    .ps_woe     (ps_woe),
    .ps_excm    (ps_excm),
    .ps_callinc (ps_callinc),
    .ps_owb     (ps_owb),
    .reg_s      (rd_data[1]),
    .reg_0      (rd_data[2]),
    .nxt_base   (e_base),
    .nxt_ws     (e_ws),
    .wr_en      (e_we),
    .wr_idx     (e_widx),
    .wr_data    (e_wdata),
    .code       (e_code),
    .ret_pc     (e_rpc),
    .excm_set   (e_exs)
  );

  // next state
  always_comb begin
    d_base = q_base;
    d_ws   = q_ws;
    d_rv   = op_valid;
    d_code = q_code;
    d_rpc  = q_rpc;
    d_owb  = q_owb;
    d_exs  = 1'b0;
    d_kind = q_kind;
    if (op_valid) begin
      d_base = e_base;
      d_ws   = e_ws;
      d_code = e_code;
      d_rpc  = e_rpc;
      d_owb  = q_base;
      d_exs  = e_exs;
      d_kind = op_kind;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_base <= '0;
      q_ws   <= NW'(1);
      q_rv   <= 1'b0;
      q_code <= 4'd0;
      q_rpc  <= '0;
      q_owb  <= '0;
      q_exs  <= 1'b0;
      q_kind <= 3'd0;
    end else begin
      q_rv  <= d_rv;
      q_exs <= d_exs;
      if (op_valid) begin
        q_base <= d_base;
        q_ws   <= d_ws;
        q_code <= d_code;
        q_rpc  <= d_rpc;
        q_owb  <= d_owb;
        q_kind <= d_kind;
      end
    end
  end

  assign rf_rdata     = rd_data[0];
  assign res_valid    = q_rv;
  assign res_code     = q_code;
  assign res_ret_pc   = q_rpc;
  assign res_owb      = q_owb;
  assign res_excm_set = q_exs;
  assign win_base     = q_base;
  assign win_start    = q_ws;

  // R3/R8: an illegal result leaves the window untouched
  p_illegal_keeps_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (q_rv && q_code == C_ILLEGAL) |-> ($stable(q_base) && $stable(q_ws)));

  // R4: a completed call-entry leaves its new base marked live
  p_entry_marks_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (q_rv && q_kind == K_ENTRY && q_code == C_DONE) |-> q_ws[q_base]);

  // R6: exception mode is requested exactly with window traps
  p_excm_only_on_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    q_exs |-> (q_rv && q_code >= C_OVF4 && q_code <= C_UNF12));

  // R9: an underflow does not alter the live bitmap
  p_underflow_keeps_bitmap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (q_rv && q_code >= C_UNF4 && q_code <= C_UNF12) |-> $stable(q_ws));

  // R10: the stack-move check never moves state
  p_stackchk_no_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (q_rv && q_kind == K_STACKCHK) |-> ($stable(q_base) && $stable(q_ws)));

  // R12: one result pulse per presented operation
  p_result_follows_op_r12: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> q_rv);

endmodule

// File: tb/rwin_controller_test.sv
module rwin_controller_test;
  localparam int CLK_PERIOD = 10;
  localparam int NAREG = 32;
  localparam int NW = NAREG / 4;
  localparam int BW = $clog2(NW);

  // op kinds and result codes (as in the requirements)
  localparam logic [2:0] OK_ENTRY = 3'd0, OK_RET = 3'd1, OK_STK = 3'd2,
                         OK_ABS = 3'd3, OK_REL = 3'd4, OK_RST = 3'd5;
  localparam int RC_DONE = 0, RC_ILL = 1, RC_OVF4 = 2, RC_OVF8 = 3, RC_OVF12 = 4,
                 RC_UNF4 = 5, RC_UNF8 = 6, RC_UNF12 = 7, RC_ALLOCA = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic op_valid;
  logic [2:0] op_kind;
  logic [3:0] op_sreg;
  logic [11:0] op_imm;
  logic [3:0] op_arg;
  logic [31:0] op_pc;
  logic ps_woe, ps_excm;
  logic [1:0] ps_callinc;
  logic [BW-1:0] ps_owb;
  logic rf_we;
  logic [3:0] rf_waddr, rf_raddr;
  logic [31:0] rf_wdata, rf_rdata;
  logic res_valid, res_excm_set;
  logic [3:0] res_code;
  logic [31:0] res_ret_pc;
  logic [BW-1:0] res_owb, win_base;
  logic [NW-1:0] win_start;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rwin_controller #(.NAREG(NAREG), .IMM_W(12)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_sreg(op_sreg), .op_imm(op_imm), .op_arg(op_arg), .op_pc(op_pc),
    .ps_woe(ps_woe), .ps_excm(ps_excm), .ps_callinc(ps_callinc), .ps_owb(ps_owb),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .rf_raddr(rf_raddr),
    .rf_rdata(rf_rdata), .res_valid(res_valid), .res_code(res_code),
    .res_ret_pc(res_ret_pc), .res_owb(res_owb), .res_excm_set(res_excm_set),
    .win_base(win_base), .win_start(win_start)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // presents one operation; returns at the negedge after the result edge
  task automatic do_op(input logic [2:0] k, input logic [3:0] s, input logic [11:0] imm,
                       input logic [3:0] arg, input logic [31:0] pc, input logic woe,
                       input logic excm, input logic [1:0] ci, input logic [BW-1:0] owb);
    @(negedge clk);
    op_valid = 1'b1; op_kind = k; op_sreg = s; op_imm = imm; op_arg = arg; op_pc = pc;
    ps_woe = woe; ps_excm = excm; ps_callinc = ci; ps_owb = owb;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic rot_abs(input logic [3:0] a);
    do_op(OK_ABS, 4'd0, 12'd0, a, 32'd0, 1'b1, 1'b0, 2'd0, '0);
  endtask

  task automatic entry(input logic [1:0] ci, input logic [3:0] s, input logic [11:0] imm,
                       input logic woe, input logic excm);
    do_op(OK_ENTRY, s, imm, 4'd0, 32'd0, woe, excm, ci, '0);
  endtask

  task automatic ret(input logic [31:0] pc, input logic woe, input logic excm);
    do_op(OK_RET, 4'd0, 12'd0, 4'd0, pc, woe, excm, 2'd0, '0);
  endtask

  task automatic wr_vis(input logic [3:0] i, input logic [31:0] d);
    @(negedge clk);
    rf_we = 1'b1; rf_waddr = i; rf_wdata = d;
    @(negedge clk);
    rf_we = 1'b0;
  endtask

  task automatic rd_vis(input logic [3:0] i, output logic [31:0] d);
    rf_raddr = i;
    #1;
    d = rf_rdata;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 base", 32'(win_base), 32'd0);
    chk("R1 bitmap", 32'(win_start), 32'h1);
    chk("R1 res_valid", 32'(res_valid), 32'd0);
  endtask

  task automatic t_mapping_rotate();
    logic [31:0] d;
    do_reset();
    wr_vis(4'd5, 32'hA5);
    rot_abs(4'd1);
    chk("R11 abs base", 32'(win_base), 32'd1);
    chk("R11 abs code", 32'(res_code), RC_DONE);
    rd_vis(4'd1, d);
    chk("R2 remap", d, 32'hA5);
    do_op(OK_REL, 4'd0, 12'd0, 4'hE, 32'd0, 1'b1, 1'b0, 2'd0, '0);
    chk("R11 rel negative", 32'(win_base), 32'd7);
    rd_vis(4'd9, d);
    chk("R2 wrap", d, 32'hA5);
    rot_abs(4'hB);
    chk("R11 abs modulo", 32'(win_base), 32'd3);
    do_op(OK_RST, 4'd0, 12'd0, 4'd0, 32'd0, 1'b1, 1'b0, 2'd0, BW'(2));
    chk("R11 restore", 32'(win_base), 32'd2);
    do_op(OK_REL, 4'd0, 12'd0, 4'd6, 32'd0, 1'b1, 1'b0, 2'd0, '0);
    chk("R11 rel wrap", 32'(win_base), 32'd0);
    chk("R11 bitmap kept", 32'(win_start), 32'h1);
  endtask

  task automatic t_entry_illegal();
    do_reset();
    entry(2'd1, 4'd4, 12'd0, 1'b1, 1'b0);
    chk("R3 sreg>3", 32'(res_code), RC_ILL);
    entry(2'd1, 4'd1, 12'd0, 1'b0, 1'b0);
    chk("R3 woe low", 32'(res_code), RC_ILL);
    entry(2'd1, 4'd1, 12'd0, 1'b1, 1'b1);
    chk("R3 excm set", 32'(res_code), RC_ILL);
    chk("R3 base", 32'(win_base), 32'd0);
    chk("R3 bitmap", 32'(win_start), 32'h1);
  endtask

  task automatic t_entry_return();
    logic [31:0] d;
    do_reset();
    wr_vis(4'd1, 32'd1000);
    entry(2'd1, 4'd1, 12'd5, 1'b1, 1'b0);
    chk("R4 code", 32'(res_code), RC_DONE);
    chk("R4 base", 32'(win_base), 32'd1);
    chk("R4 bitmap", 32'(win_start), 32'h3);
    chk("R6 no excm", 32'(res_excm_set), 32'd0);
    rd_vis(4'd1, d);
    chk("R4 stack reg", d, 32'd960);
    wr_vis(4'd0, 32'h4000_1234);
    ret(32'h8765_4320, 1'b1, 1'b0);
    chk("R7 code", 32'(res_code), RC_DONE);
    chk("R7 ret pc", res_ret_pc, 32'h8000_1234);
    chk("R7 base", 32'(win_base), 32'd0);
    chk("R7 bitmap", 32'(win_start), 32'h1);
    // illegal returns
    wr_vis(4'd0, 32'h0000_0010);
    ret(32'hFFFF_0000, 1'b1, 1'b0);
    chk("R8 n zero", 32'(res_code), RC_ILL);
    chk("R8 pc zero", res_ret_pc, 32'd0);
    entry(2'd2, 4'd0, 12'd0, 1'b1, 1'b0);
    chk("R4 ci2 base", 32'(win_base), 32'd2);
    chk("R4 ci2 bitmap", 32'(win_start), 32'h5);
    wr_vis(4'd0, 32'h4000_0000);
    ret(32'd0, 1'b1, 1'b0);
    chk("R8 m differs", 32'(res_code), RC_ILL);
    wr_vis(4'd0, 32'h8000_0000);
    ret(32'd0, 1'b1, 1'b1);
    chk("R8 excm", 32'(res_code), RC_ILL);
    ret(32'd0, 1'b0, 1'b0);
    chk("R8 woe", 32'(res_code), RC_ILL);
    chk("R8 base kept", 32'(win_base), 32'd2);
    ret(32'h4000_0000, 1'b1, 1'b0);
    chk("R7 n2 code", 32'(res_code), RC_DONE);
    chk("R7 n2 pc", res_ret_pc, 32'h4000_0000);
    chk("R7 n2 base", 32'(win_base), 32'd0);
    chk("R7 n2 bitmap", 32'(win_start), 32'h1);
  endtask

  task automatic t_underflow();
    logic [31:0] top [3] = '{32'h4000_0000, 32'h8000_0000, 32'hC000_0000};
    int codes [3] = '{RC_UNF4, RC_UNF8, RC_UNF12};
    do_reset();
    for (int i = 0; i < 3; i++) begin
      rot_abs(4'd0);
      chk("R6 no excm on rotate", 32'(res_excm_set), 32'd0);
      wr_vis(4'd0, top[i]);
      ret(32'd0, 1'b1, 1'b0);
      chk("R9 code", 32'(res_code), 32'(codes[i]));
      chk("R9 base", 32'(win_base), 32'(8 - (i + 1)));
      chk("R9 bitmap", 32'(win_start), 32'h1);
      chk("R6 excm", 32'(res_excm_set), 32'd1);
      chk("R6 owb", 32'(res_owb), 32'd0);
    end
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    do_reset();
    entry(2'd2, 4'd0, 12'd0, 1'b1, 1'b0);
    chk("R4 setup bitmap", 32'(win_start), 32'h5);
    rot_abs(4'd7);
    entry(2'd1, 4'd0, 12'd0, 1'b1, 1'b0);
    chk("R5 ovf8 code", 32'(res_code), RC_OVF8);
    chk("R5 ovf8 base", 32'(win_base), 32'd0);
    chk("R5 ovf8 bitmap", 32'(win_start), 32'h5);
    chk("R6 ovf owb", 32'(res_owb), 32'd7);
    chk("R6 ovf excm", 32'(res_excm_set), 32'd1);
    rot_abs(4'd1);
    entry(2'd1, 4'd0, 12'd0, 1'b1, 1'b0);
    chk("R5 ovf12 code", 32'(res_code), RC_OVF12);
    chk("R5 ovf12 base", 32'(win_base), 32'd2);
    chk("R6 ovf12 owb", 32'(res_owb), 32'd1);
    rot_abs(4'd6);
    entry(2'd1, 4'd0, 12'd0, 1'b1, 1'b0);
    chk("R4 base7", 32'(win_start), 32'h85);
    rot_abs(4'd6);
    wr_vis(4'd8, 32'h55);
    entry(2'd2, 4'd0, 12'd0, 1'b1, 1'b0);
    chk("R5 ovf4 code", 32'(res_code), RC_OVF4);
    chk("R5 ovf4 base", 32'(win_base), 32'd7);
    chk("R5 ovf4 bitmap", 32'(win_start), 32'h85);
    rd_vis(4'd4, d);
    chk("R5 no write", d, 32'h55);
  endtask

  task automatic t_stack_misc();
    do_reset();
    do_op(OK_STK, 4'd0, 12'd0, 4'd0, 32'd0, 1'b1, 1'b0, 2'd0, '0);
    chk("R10 alloca", 32'(res_code), RC_ALLOCA);
    chk("R10 base kept", 32'(win_base), 32'd0);
    rot_abs(4'd2);
    do_op(OK_STK, 4'd0, 12'd0, 4'd0, 32'd0, 1'b1, 1'b0, 2'd0, '0);
    chk("R10 ok", 32'(res_code), RC_DONE);
    chk("R10 base kept 2", 32'(win_base), 32'd2);
    chk("R12 pulse high", 32'(res_valid), 32'd1);
    @(negedge clk);
    chk("R12 pulse low", 32'(res_valid), 32'd0);
    do_op(3'd6, 4'd0, 12'd0, 4'd5, 32'd0, 1'b1, 1'b0, 2'd0, '0);
    chk("R3 unused kind", 32'(res_code), RC_ILL);
    chk("R3 unused base", 32'(win_base), 32'd2);
  endtask

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_kind = 3'd0; op_sreg = 4'd0; op_imm = 12'd0;
    op_arg = 4'd0; op_pc = 32'd0; ps_woe = 1'b1; ps_excm = 1'b0; ps_callinc = 2'd0;
    ps_owb = '0; rf_we = 1'b0; rf_waddr = 4'd0; rf_wdata = 32'd0; rf_raddr = 4'd0;
    t_reset();
    t_mapping_rotate();
    t_entry_illegal();
    t_entry_return();
    t_underflow();
    t_overflow();
    t_stack_misc();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule